// File: doc/BRIEF.md
# Link Failure Watchdog

This block sits at the receiving end of an internal link. The link carries the channel command word across an isolation barrier and sends it again once per fixed period. Each arriving frame comes with a strobe, a link-level valid flag, a payload of `WIDTH` bits and one parity bit. The block accepts a frame only when the link flag is high and the parity is even. An accepted frame drives the channel enables directly. A rejected frame keeps the last accepted state in place.

The block counts rejected frames in a row. A period with no frame also counts as a rejection: the block measures this gap with a local tick. Once the count reaches `FAIL_LIMIT`, every channel is switched off. The channels stay off until an accepted frame arrives, and that frame takes effect at once. Each rejection stays well inside the retransmission period, so a short disturbance on the barrier does not drop the loads. A dead link still switches them off within a bounded time.

Top module: `link_fail_watchdog`

## Requirements
- R1: After reset `chan_en` is all zeros. It stays all zeros through any number of rejected frames until the first accepted frame.
- R2: A frame is accepted when `frm_stb`, `frm_link_ok` and even parity all hold in the same cycle. Even parity means the XOR of `frm_data` and `frm_par` together is 0. On the clock edge that samples an accepted frame, `chan_en` takes the value of `frm_data`, and bit i of `chan_en` enables channel i.
- R3: A strobed frame with odd parity over `frm_data` and `frm_par` is rejected and does not load its payload.
- R4: A strobed frame with `frm_link_ok` low is rejected and does not load its payload, even when its parity is even.
- R5: For up to `FAIL_LIMIT`-1 rejections in a row, `chan_en` keeps the last accepted payload.
- R6: On the edge that samples the `FAIL_LIMIT`-th rejection in a row, `chan_en` becomes all zeros.
- R7: A missing frame counts as one rejection. A frame is missing when `PERIOD_TICKS + PERIOD_TICKS/2` tick pulses arrive without a strobe. The tick window restarts after each such count and in every cycle that has a strobe, even when that cycle also has a tick.
- R8: Further rejections after shutdown keep `chan_en` at zero. A single accepted frame then restores the outputs immediately.
- R9: An accepted frame clears the count of rejections in a row. After `FAIL_LIMIT`-1 rejections, one accepted frame and another `FAIL_LIMIT`-1 rejections, the outputs stay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse of the local timebase |
| frm_stb | input | 1 | One-cycle pulse marking a received frame |
| frm_link_ok | input | 1 | Link-level validity flag of the frame |
| frm_data | input | WIDTH | Frame payload, one bit per channel |
| frm_par | input | 1 | Parity bit making the frame's bit count even |
| chan_en | output | WIDTH | Registered channel enables |

## Verification
The bench builds the block with `WIDTH` 8, `FAIL_LIMIT` 4 and `PERIOD_TICKS` 4. With these values a missing frame is declared after six ticks, so a full shutdown from silence takes only 24 ticks. The restart of the window by a strobe, including a strobe that lands on the same cycle as a tick, can then be shown within a few dozen cycles. The small limit keeps these sequences within reach: the fourth rejection, the saturated count after shutdown, and the clearing of a partial count by one good frame, each mixing parity, link-flag and timeout rejections.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
  // Ticks without a strobe before a frame is declared missing (1.5 periods).
  function automatic int miss_ticks(input int period);
    return period + period / 2;
  endfunction
endpackage

// File: rtl/lfw_frame_check.sv
module lfw_frame_check #(
  parameter int WIDTH = 8
) (
  input  logic             stb,
  input  logic             link_ok,
  input  logic [WIDTH-1:0] data,
  input  logic             par,
  output logic             acc,
  output logic             rej
);
  logic par_even;

  always_comb begin
    par_even = ~(^{data, par});
    acc      = stb & link_ok & par_even;
    rej      = stb & ~(link_ok & par_even);
  end
endmodule

// File: rtl/lfw_gap_timer.sv
module lfw_gap_timer #(
  parameter int TMO = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic stb,
  output logic miss
);
  localparam int CW = (TMO > 2) ? $clog2(TMO) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic [CW-1:0] cnt;

  always_comb miss = tick & ~stb & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || stb) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R7: a strobe restarts the window, even on a tick cycle
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    stb |=> (cnt == '0));

  // R7: a declared miss starts a fresh window
  p_miss_rewind_r7: assert property (@(posedge clk) disable iff (rst)
    miss |=> (cnt == '0));
endmodule

// File: rtl/lfw_err_count.sv
module lfw_err_count #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_good,
  input  logic ev_bad,
  output logic trip,
  output logic failed
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] EDGE_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    failed = (cnt == LIM_V);
    trip   = ev_bad & ~ev_good & (cnt >= EDGE_V);
  end

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= LIM_V;
    else if (ev_good)                 cnt <= '0;
    else if (ev_bad && cnt != LIM_V)  cnt <= cnt + 1'b1;
  end

  // R9: an accepted frame clears the run of rejections
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ev_good |=> (cnt == '0));

  // R5: each rejection below the limit advances the count by one
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_bad && !ev_good && cnt != LIM_V) |=> (cnt == $past(cnt) + 1'b1));

  // R8: the count saturates at the limit
  p_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (failed && !ev_good) |=> failed);
endmodule

// File: rtl/link_fail_watchdog.sv
module link_fail_watchdog #(
  parameter int WIDTH        = 8,
  parameter int FAIL_LIMIT   = 4,
  parameter int PERIOD_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             frm_stb,
  input  logic             frm_link_ok,
  input  logic [WIDTH-1:0] frm_data,
  input  logic             frm_par,
  output logic [WIDTH-1:0] chan_en
);
  localparam int TMO = lfw_pkg::miss_ticks(PERIOD_TICKS);

  logic acc, rej, miss, trip, failed;

  lfw_frame_check #(.WIDTH(WIDTH)) u_check (
    .stb(frm_stb), .link_ok(frm_link_ok), .data(frm_data), .par(frm_par),
    .acc(acc), .rej(rej)
  );

  lfw_gap_timer #(.TMO(TMO)) u_gap (
    .clk(clk), .rst(rst), .tick(tick), .stb(frm_stb), .miss(miss)
  );

  lfw_err_count #(.LIMIT(FAIL_LIMIT)) u_err (
    .clk(clk), .rst(rst), .ev_good(acc), .ev_bad(rej | miss),
    .trip(trip), .failed(failed)
  );

  always_ff @(posedge clk) begin
    if (rst)       chan_en <= '0;
    else if (acc)  chan_en <= frm_data;
    else if (trip) chan_en <= '0;
  end

  // R2: an accepted frame lands on the outputs at the next edge
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    acc |=> (chan_en == $past(frm_data)));

  // R6: outputs are off whenever the failure count is saturated
  p_off_r6: assert property (@(posedge clk) disable iff (rst)
    failed |-> (chan_en == '0));

  // R3: a rejected frame never loads a new pattern
  p_reject_r3: assert property (@(posedge clk) disable iff (rst)
    rej |=> (chan_en == '0 || chan_en == $past(chan_en)));
endmodule

// File: tb/test_link_fail_watchdog.sv
module test_link_fail_watchdog;
  localparam int W   = 8;
  localparam int LIM = 4;
  localparam int PER = 4;
  localparam int TMO = PER + PER / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         frm_stb = 1'b0;
  logic         frm_link_ok = 1'b0;
  logic [W-1:0] frm_data = '0;
  logic         frm_par = 1'b0;
  logic [W-1:0] chan_en;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [W-1:0] q_exp[$];
  string        q_tag[$];

  // reference state, from the requirements
  logic [W-1:0] m_en = '0;
  int           m_cnt = LIM;
  int           m_gap = 0;

  always #2 clk = ~clk;

  link_fail_watchdog #(.WIDTH(W), .FAIL_LIMIT(LIM), .PERIOD_TICKS(PER)) i_link_fail_watchdog (
    .clk(clk), .rst(rst), .tick(tick), .frm_stb(frm_stb), .frm_link_ok(frm_link_ok),
    .frm_data(frm_data), .frm_par(frm_par), .chan_en(chan_en)
  );

  task automatic step(input bit stb, input bit ok, input logic [W-1:0] d,
                      input bit par, input bit tk, input string tag);
    bit good, bad, miss;
    @(negedge clk);
    frm_stb = stb; frm_link_ok = ok; frm_data = d; frm_par = par; tick = tk;
    good = stb && ok && ((^{d, par}) == 1'b0);
    bad  = stb && !good;
    miss = tk && !stb && (m_gap == TMO - 1);
    if (stb)      m_gap = 0;
    else if (tk)  m_gap = (m_gap == TMO - 1) ? 0 : m_gap + 1;
    if (good) begin
      m_cnt = 0; m_en = d;
    end else if (bad || miss) begin
      if (m_cnt >= LIM - 1) m_en = '0;
      if (m_cnt < LIM) m_cnt = m_cnt + 1;
    end
    q_exp.push_back(m_en);
    q_tag.push_back(tag);
  endtask

  task automatic good_frame(input logic [W-1:0] d, input string tag);
    step(1, 1, d, ^d, 0, tag);
  endtask
  task automatic par_bad(input logic [W-1:0] d, input string tag);
    step(1, 1, d, ~(^d), 0, tag);
  endtask
  task automatic link_bad(input logic [W-1:0] d, input string tag);
    step(1, 0, d, ^d, 0, tag);
  endtask
  task automatic tick_only(input string tag);
    step(0, 0, '0, 0, 1, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, '0, 0, 0, tag);
  endtask

  // monitor: compares after the edge that captured each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_run++;
        if (chan_en !== e) begin
          n_fail++;
          $display("FAIL %s: chan_en=%h expected %h", t, chan_en, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_run++;
    if (chan_en !== '0) begin
      n_fail++;
      $display("FAIL R1: chan_en=%h expected 00 after reset", chan_en);
    end

    // R1: rejects before any accepted frame keep outputs off
    par_bad(8'hFF, "R1");
    link_bad(8'h0F, "R1");
    idle("R1");

    // R2: accepted frames load the payload
    good_frame(8'hA5, "R2");
    good_frame(8'h3C, "R2");
    good_frame(8'h01, "R2");
    idle("R2");

    // R3, R4, R5, R6: four rejections in a row
    par_bad(8'hFF, "R3");
    link_bad(8'hF0, "R4");
    par_bad(8'h80, "R5");
    idle("R5");
    link_bad(8'h7E, "R6");

    // R8: saturated, then immediate recovery
    par_bad(8'h11, "R8");
    link_bad(8'h22, "R8");
    good_frame(8'h5A, "R8");

    // R9: partial run cleared by a good frame
    par_bad(8'h00, "R9");
    link_bad(8'h00, "R9");
    par_bad(8'h00, "R9");
    good_frame(8'h77, "R9");
    par_bad(8'h00, "R9");
    link_bad(8'h00, "R9");
    par_bad(8'h00, "R9");
    idle("R9");
    good_frame(8'h77, "R9");

    // R7: silence, four missed windows switch everything off
    for (int i = 0; i < LIM * TMO; i++) begin
      tick_only("R7");
      idle("R7");
    end

    // R7: strobes (one on a tick cycle) keep restarting the window
    good_frame(8'hC3, "R7");
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < TMO - 1; i++) tick_only("R7");
      step(1, 1, 8'hC3, ^8'hC3, 1, "R7");
    end

    // R7 with R6: two missing windows plus two bad frames end in shutdown
    for (int i = 0; i < 2 * TMO; i++) tick_only("R7");
    par_bad(8'h00, "R6");
    link_bad(8'h00, "R6");
    idle("R6");
    good_frame(8'h96, "R8");
    idle("R2");

    repeat (4) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule